// File: doc/BRIEF.md
# PS/2 Keyboard Device-Side Transmitter

This block plays the keyboard end of a PS/2 link. A requester hands it one key event at a time: an 8-bit key code plus three flags (extended, release, pause). The block expands the event into the matching make or break byte sequence and sends every byte as an 11-bit serial frame. It generates the link clock itself. Both the clock line and the data line are open-drain: the block only ever pulls a line low through a drive-enable output, and it watches the wired clock line through a sense input so that a host holding the clock low can stall or interrupt it.

The request side is a valid/ready stream with no queue behind it. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the last stop bit of the event's final byte has been sent. While `req_ready` is low, `req_valid` is ignored and nothing is stored, so a requester that wants its event delivered must hold `req_valid` until it sees `req_ready`. The bit timing comes from the parameter `HALF_DIV`, which is the number of system clock cycles in half a link clock period. The default of 2000 cycles at 50 MHz gives a 12.5 kHz link clock with 40 us halves.

Top module: `kbd_dev_tx`

## Requirements
- R1: Each byte goes out as 11 bits, each sampled on a falling clock edge: a start bit of 0, then data bit 0 through data bit 7, then a parity bit equal to the inverse of the XOR of the eight data bits (odd parity), then a stop bit of 1. A 1 is sent by releasing the data line and a 0 by driving it low.
- R2: The data line changes only when the link clock goes from low to high. It is stable across every falling edge. Each low half of the link clock lasts exactly `HALF_DIV` cycles.
- R3: A press with release=0 and pause=0 sends only the key code. With extended=1 it sends 8'hE0 and then the key code.
- R4: A release (release=1, pause=0) sends 8'hF0 and then the key code. With extended=1 it sends 8'hE0, 8'hF0 and then the key code.
- R5: A request with pause=1 sends 8'hE1, 8'h14, 8'h77, 8'hE1, 8'hF0, 8'h14, 8'hF0, 8'h77 in that order. The key code, extended and release inputs have no effect on it.
- R6: `req_ready` is low from the cycle after acceptance until the final stop bit of the event has been sent. A `req_valid` seen while `req_ready` is low starts nothing.
- R7: Before the start bit of every frame, both lines are released for at least 2*`HALF_DIV` cycles (one bit time).
- R8: While the sensed clock line is held low by the host before a frame, the block drives neither line and waits for the release.
- R9: If the host pulls the clock low during a high half of a frame, the block releases both lines in the next cycle. Once the line is free, it resends that whole byte.
- R10: After reset and whenever `req_ready` is high, neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Key event offered |
| req_ready | output | 1 | Idle and able to take an event |
| req_code | input | 8 | Key code |
| req_ext | input | 1 | Key uses the extended prefix |
| req_rel | input | 1 | Event is a release |
| req_pause | input | 1 | Send the pause-key burst |
| line_clk_drive | output | 1 | Pull the link clock line low |
| line_clk_sense | input | 1 | Sensed level of the wired clock line |
| line_dat_drive | output | 1 | Pull the link data line low |

## Verification
The assertions check on every cycle that the lines are released whenever the block is ready, and that `req_ready` drops right after acceptance. They also check that the data drive holds steady through each falling edge and each low half, that a clock held low by the host stops the block from starting to drive the clock, and that a host pull in a high half releases the data line at once. Other behaviour can only be shown by the bench's scenarios, which decode the wire: the exact byte sequences for press, release, extended and pause events, odd parity across code values, the length of the low half and the inter-frame gap, a request ignored while busy, and the complete resend of a byte after a host abort.

// File: rtl/kbd_dev_pkg.sv
package kbd_dev_pkg;

  localparam int SEQ_MAX = 8;
  localparam int LEN_W   = $clog2(SEQ_MAX + 1);
  localparam int IDX_W   = $clog2(SEQ_MAX);

  localparam logic [7:0] CODE_EXT   = 8'hE0;
  localparam logic [7:0] CODE_PAUSE = 8'hE1;
  localparam logic [7:0] CODE_BRK   = 8'hF0;
  localparam logic [7:0] PAUSE_MID  = 8'h14;
  localparam logic [7:0] PAUSE_END  = 8'h77;

  typedef struct packed {
    logic [LEN_W-1:0]            len;
    logic [SEQ_MAX-1:0][7:0]     bytes;
  } key_seq_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_HOLD,
    TX_GAP,
    TX_HI,
    TX_LO
  } tx_state_e;

  function automatic logic odd_parity(input logic [7:0] d);
    return ~(^d);
  endfunction

  function automatic key_seq_t build_seq(input logic [7:0] code, input logic ext,
                                         input logic rel, input logic pause);
    key_seq_t s;
    int       n;
    s = '0;
    n = 0;
    if (pause) begin
      s.bytes[0] = CODE_PAUSE;
      s.bytes[1] = PAUSE_MID;
      s.bytes[2] = PAUSE_END;
      s.bytes[3] = CODE_PAUSE;
      s.bytes[4] = CODE_BRK;
      s.bytes[5] = PAUSE_MID;
      s.bytes[6] = CODE_BRK;
      s.bytes[7] = PAUSE_END;
      s.len      = LEN_W'(SEQ_MAX);
    end else begin
      if (ext) begin
        s.bytes[n] = CODE_EXT;
        n = n + 1;
      end
      if (rel) begin
        s.bytes[n] = CODE_BRK;
        n = n + 1;
      end
      s.bytes[n] = code;
      s.len      = LEN_W'(n + 1);
    end
    return s;
  endfunction

endpackage

// File: rtl/kbd_seq_ctrl.sv
module kbd_seq_ctrl
  import kbd_dev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_code,
  input  logic       req_ext,
  input  logic       req_rel,
  input  logic       req_pause,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  input  logic       byte_ready,
  input  logic       frame_done
);

  logic             busy_q;
  logic             sent_q;
  logic [IDX_W-1:0] idx_q;
  key_seq_t         seq_q;

  logic accept;
  logic last_byte;

  assign accept    = req_valid && !busy_q;
  assign last_byte = (LEN_W'(idx_q) + LEN_W'(1)) == seq_q.len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      idx_q  <= '0;
      seq_q  <= '0;
    end else if (accept) begin
      seq_q  <= build_seq(req_code, req_ext, req_rel, req_pause);
      idx_q  <= '0;
      busy_q <= 1'b1;
      sent_q <= 1'b0;
    end else if (busy_q) begin
      if (frame_done) begin
        sent_q <= 1'b0;
        if (last_byte) busy_q <= 1'b0;
        else           idx_q  <= idx_q + IDX_W'(1);
      end else if (byte_valid && byte_ready) begin
        sent_q <= 1'b1;
      end
    end
  end

  assign req_ready  = !busy_q;
  assign byte_valid = busy_q && !sent_q;
  assign byte_data  = seq_q.bytes[idx_q];

endmodule

// File: rtl/kbd_frame_tx.sv
module kbd_frame_tx
  import kbd_dev_pkg::*;
#(
  parameter int HALF_DIV = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       frame_done,
  input  logic       clk_sense,
  output logic       clk_drive,
  output logic       dat_drive
);

  localparam int GAP_CYC    = 2 * HALF_DIV;
  localparam int CW         = $clog2(GAP_CYC + 1);
  localparam int FRAME_BITS = 11;
  localparam int BW         = $clog2(FRAME_BITS);

  tx_state_e             st_q;
  logic [CW-1:0]         cnt_q;
  logic [FRAME_BITS-1:0] frm_q;
  logic [BW-1:0]         bit_q;
  logic                  done_q;
  logic                  tick;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      frm_q  <= '1;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        TX_IDLE: begin
          if (in_valid) begin
            frm_q <= {1'b1, odd_parity(in_byte), in_byte, 1'b0};
            st_q  <= TX_HOLD;
          end
        end
        TX_HOLD: begin
          if (clk_sense) begin
            cnt_q <= CW'(GAP_CYC - 1);
            st_q  <= TX_GAP;
          end
        end
        TX_GAP: begin
          if (!clk_sense) begin
            st_q <= TX_HOLD;
          end else if (tick) begin
            bit_q <= '0;
            cnt_q <= CW'(HALF_DIV - 1);
            st_q  <= TX_HI;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        TX_HI: begin
          if (!clk_sense) begin
            bit_q <= '0;
            st_q  <= TX_HOLD;
          end else if (tick) begin
            cnt_q <= CW'(HALF_DIV - 1);
            st_q  <= TX_LO;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        TX_LO: begin
          if (tick) begin
            if (bit_q == BW'(FRAME_BITS - 1)) begin
              done_q <= 1'b1;
              st_q   <= TX_IDLE;
            end else begin
              bit_q <= bit_q + BW'(1);
              cnt_q <= CW'(HALF_DIV - 1);
              st_q  <= TX_HI;
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign in_ready   = (st_q == TX_IDLE);
  assign frame_done = done_q;
  assign clk_drive  = (st_q == TX_LO);
  assign dat_drive  = ((st_q == TX_HI) || (st_q == TX_LO)) && !frm_q[bit_q];

endmodule

// File: rtl/kbd_dev_tx.sv
module kbd_dev_tx #(
  parameter int HALF_DIV = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_code,
  input  logic       req_ext,
  input  logic       req_rel,
  input  logic       req_pause,
  output logic       line_clk_drive,
  input  logic       line_clk_sense,
  output logic       line_dat_drive
);

  logic       byte_valid;
  logic       byte_ready;
  logic [7:0] byte_data;
  logic       frame_done;

  kbd_seq_ctrl u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_code   (req_code),
    .req_ext    (req_ext),
    .req_rel    (req_rel),
    .req_pause  (req_pause),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .byte_ready (byte_ready),
    .frame_done (frame_done)
  );

  kbd_frame_tx #(.HALF_DIV(HALF_DIV)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (byte_valid),
    .in_byte    (byte_data),
    .in_ready   (byte_ready),
    .frame_done (frame_done),
    .clk_sense  (line_clk_sense),
    .clk_drive  (line_clk_drive),
    .dat_drive  (line_dat_drive)
  );

endmodule

// File: rtl/kbd_dev_tx_chk.sv
module kbd_dev_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_code,
  input logic       req_ext,
  input logic       req_rel,
  input logic       req_pause,
  input logic       line_clk_drive,
  input logic       line_clk_sense,
  input logic       line_dat_drive
);

  p_idle_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!line_clk_drive && !line_dat_drive));

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_data_at_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_clk_drive) |-> $stable(line_dat_drive));

  p_data_hold_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_clk_drive && $past(line_clk_drive)) |-> $stable(line_dat_drive));

  p_host_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_clk_sense && !line_clk_drive) |=> !line_clk_drive);

  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_clk_sense && !line_clk_drive && line_dat_drive) |=> !line_dat_drive);

endmodule

bind kbd_dev_tx kbd_dev_tx_chk u_chk (.*);

// File: tb/tb_kbd_dev_tx.sv
module tb_kbd_dev_tx;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [7:0] req_code;
  logic       req_ext, req_rel, req_pause;
  logic       host_hold;
  logic       req_ready;
  logic       cdrv, ddrv;
  logic       csense;

  always #10 clk = ~clk;

  assign csense = ~cdrv & ~host_hold;

  kbd_dev_tx #(.HALF_DIV(HALF)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_code       (req_code),
    .req_ext        (req_ext),
    .req_rel        (req_rel),
    .req_pause      (req_pause),
    .line_clk_drive (cdrv),
    .line_clk_sense (csense),
    .line_dat_drive (ddrv)
  );

  int nchk = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // wire-level receiver
  logic        prev_cl = 1'b1, prev_dl = 1'b1, mc, md;
  int          bitn = 0, lowcnt = 0, idlecnt = 0;
  bit          dev_low = 1'b0;
  logic [10:0] sh;
  logic [7:0]  rx [0:511];
  int          rx_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      mc = ~cdrv & ~host_hold;
      md = ~ddrv;
      if (host_hold) begin
        bitn = 0; idlecnt = 0; dev_low = 1'b0;
      end else begin
        if (prev_cl && mc && prev_dl && !md && bitn == 0)
          chk(idlecnt >= 2*HALF, "R7 idle gap before start bit", idlecnt, 2*HALF);
        if (prev_cl && !mc) begin
          chk(md == prev_dl, "R2 data stable across falling edge", md, prev_dl);
          sh[bitn[3:0]] = md;
          bitn++;
          lowcnt = 0;
          dev_low = 1'b1;
          if (bitn == 11) begin
            chk(sh[0] == 1'b0 && sh[10] == 1'b1 && sh[9] == ~(^sh[8:1]),
                "R1 start/parity/stop", sh, {1'b1, ~(^sh[8:1]), sh[8:1], 1'b0});
            rx[rx_n[8:0]] = sh[8:1];
            rx_n++;
            bitn = 0;
          end
        end
        if (!mc) lowcnt++;
        if (!prev_cl && mc && dev_low) begin
          chk(lowcnt == HALF, "R2 clock low half length", lowcnt, HALF);
          dev_low = 1'b0;
        end
        if (mc && md) idlecnt++;
        else          idlecnt = 0;
      end
      prev_cl = mc;
      prev_dl = md;
    end
  end

  function automatic int exp_seq(input logic [7:0] c, input bit e, input bit r, input bit p,
                                 output logic [7:0] q [0:7]);
    int n;
    for (int i = 0; i < 8; i++) q[i] = 8'h00;
    if (p) begin
      q[0] = 8'hE1; q[1] = 8'h14; q[2] = 8'h77; q[3] = 8'hE1;
      q[4] = 8'hF0; q[5] = 8'h14; q[6] = 8'hF0; q[7] = 8'h77;
      return 8;
    end
    n = 0;
    if (e) begin q[n] = 8'hE0; n++; end
    if (r) begin q[n] = 8'hF0; n++; end
    q[n] = c;
    return n + 1;
  endfunction

  task automatic issue(input logic [7:0] c, input bit e, input bit r, input bit p,
                       output int base);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    base = rx_n;
    req_code = c; req_ext = e; req_rel = r; req_pause = p;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 ready low after acceptance", req_ready, 0);
  endtask

  task automatic finish_req(input logic [7:0] c, input bit e, input bit r, input bit p,
                            input int base);
    logic [7:0] q [0:7];
    int n;
    string tag;
    while (!req_ready) @(negedge clk);
    n = exp_seq(c, e, r, p, q);
    tag = p ? "R5 pause byte" : (r ? "R4 release byte" : "R3 press byte");
    chk(rx_n - base == n, "R6 all bytes sent when ready rises", rx_n - base, n);
    for (int i = 0; i < n; i++)
      chk(rx[(base + i) % 512] == q[i], tag, rx[(base + i) % 512], q[i]);
    chk(!cdrv && !ddrv, "R10 lines released when ready", {cdrv, ddrv}, 0);
  endtask

  task automatic run_req(input logic [7:0] c, input bit e, input bit r, input bit p);
    int b;
    issue(c, e, r, p, b);
    finish_req(c, e, r, p, b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int b;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; req_valid = 1'b0; req_code = 8'h00;
    req_ext = 1'b0; req_rel = 1'b0; req_pause = 1'b0; host_hold = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(!cdrv && !ddrv, "R10 lines released after reset", {cdrv, ddrv}, 0);

    // R3 / R4 directed, parity corner codes
    run_req(8'h1C, 0, 0, 0);
    run_req(8'h75, 1, 0, 0);
    run_req(8'h1C, 0, 1, 0);
    run_req(8'h75, 1, 1, 0);
    run_req(8'h00, 0, 0, 0);
    run_req(8'hFF, 0, 0, 0);
    run_req(8'h07, 0, 0, 0);

    // R5 pause: other fields have no effect
    run_req(8'h5A, 1, 1, 1);

    // R6 request while busy is ignored
    issue(8'h6B, 1, 0, 0, b);
    repeat (5) @(negedge clk);
    req_code = 8'h22; req_ext = 1'b0; req_rel = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R6 still busy during ignored request", req_ready, 0);
    finish_req(8'h6B, 1, 0, 0, b);
    repeat (3 * 24 * HALF) @(negedge clk);
    chk(rx_n == b + 2, "R6 ignored request sent nothing", rx_n - b, 2);

    // R8 host holds clock before the frame
    host_hold = 1'b1;
    issue(8'h4D, 0, 0, 0, b);
    repeat (60) @(negedge clk);
    chk(!cdrv && !ddrv, "R8 no drive while host holds clock", {cdrv, ddrv}, 0);
    chk(rx_n == b, "R8 nothing sent while held", rx_n - b, 0);
    host_hold = 1'b0;
    finish_req(8'h4D, 0, 0, 0, b);

    // R9 host aborts mid-frame; whole byte is resent
    issue(8'h71, 1, 1, 0, b);
    while (!(bitn >= 4 && !cdrv)) @(negedge clk);
    host_hold = 1'b1;
    repeat (2) @(negedge clk);
    chk(!cdrv && !ddrv, "R9 lines released after abort", {cdrv, ddrv}, 0);
    repeat (30) @(negedge clk);
    host_hold = 1'b0;
    finish_req(8'h71, 1, 1, 0, b);

    // constrained random mix
    for (int k = 0; k < 24; k++) begin
      logic [7:0] c;
      bit e, r, p;
      c = 8'($urandom);
      e = 1'($urandom);
      r = 1'($urandom);
      p = ($urandom % 6) == 0;
      run_req(c, e, r, p);
    end

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule